// File: doc/BRIEF.md
# USB Start-of-Frame Number Tracker

This block follows start-of-frame (SOF) packets on a USB device's receive path and keeps the current 11-bit frame number together with two status flags: one for a good frame and one for a bad frame. It sits after the packet decoder. The packet layer supplies already-decoded events: a strobe when an SOF packet identifier is seen, the 11-bit frame field, a flag that says whether the packet check passed, and an end-of-packet strobe. Line decoding, bit unstuffing and the CRC5 computation are outside this block.

The flags are cleared as soon as the SOF identifier arrives. The frame number and the result of the packet check are written into the register only when the packet ends. A start-of-frame interrupt request pulses right after the identifier, so firmware or isochronous logic can synchronise without waiting for the rest of the packet.

The state is packed into a 32-bit status word, which can be read through a small read port:

- bits 10..0 hold the frame number;
- bit 16 holds the frame-error flag;
- bit 17 holds the frame-OK flag.

Top module: `usb_sof_tracker`

## Requirements
- R1: After a synchronous active-low reset, the frame number, frame-OK and frame-error are all zero, `sof_irq` is low, and `rd_data` reads zero.
- R2: `sof_irq` is high for exactly the one cycle that follows a cycle in which `sof_pid_stb` was sampled high. It does not depend on the end of the packet.
- R3: A sampled `sof_pid_stb` clears both frame-OK and frame-error in the next cycle.
- R4: The frame number does not change when the identifier arrives. It takes the value of `frame_field` only at a sampled `eop_stb` that has `crc_ok` high and ends a pending SOF packet.
- R5: A pending SOF packet that ends with `crc_ok` high sets frame-OK (bit 17) and leaves frame-error low.
- R6: A pending SOF packet that ends with `crc_ok` low sets frame-error (bit 16), leaves frame-OK low, and keeps the previous frame number.
- R7: Frame-OK and frame-error are never high at the same time.
- R8: An `eop_stb` that arrives when no SOF packet is pending has no effect on the status word. This includes a second end-of-packet after a packet has already been committed.
- R9: When `sof_pid_stb` and `eop_stb` are high in the same cycle, the identifier wins. That end-of-packet is ignored, and the new packet is pending.
- R10: With `READ_REG` = 1, `rd_data` shows, one cycle after a read, the status word if `rd_addr` equalled `FRAME_ADDR`. It shows zero for any other address or when `rd_en` was low. The status word is frame number in bits 10..0, frame-error in bit 16, frame-OK in bit 17, and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_pid_stb | input | 1 | One-cycle strobe: SOF packet identifier decoded |
| eop_stb | input | 1 | One-cycle strobe: end of the current packet |
| crc_ok | input | 1 | Packet check result, valid with `eop_stb` |
| frame_field | input | 11 | Decoded frame field, valid with `eop_stb` |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data |
| sof_irq | output | 1 | Start-of-frame interrupt request pulse |

## Verification
The bench builds the block with its defaults: `ADDR_W` = 4, `FRAME_ADDR` = 0 and the registered read variant (`READ_REG` = 1).

Because the frame field is the full 11 bits, both the all-ones value 0x7FF and zero can be applied directly, so every bit of the number field can be seen moving. With four address bits, the bench can read addresses other than `FRAME_ADDR` and confirm they return zero.

The one-cycle read delay puts the bench's comparison one cycle behind each state change. This makes the exact cycle in which the flags clear (at the identifier) and the number commits (at the end of packet) visible at the port.

// File: rtl/usb_sof_pkg.sv
// Shared widths, bit positions and status record for the SOF tracker.
// Assumes a 32-bit status word; flag positions are decoded by software.
package usb_sof_pkg;

    localparam int FRAME_W = 11;
    localparam int WORD_W  = 32;
    localparam int ERR_POS = 16;
    localparam int OK_POS  = 17;

    typedef struct packed {
        logic               ok;
        logic               err;
        logic [FRAME_W-1:0] num;
    } frame_stat_t;

    // Place the status record into the software-visible word.
    function automatic logic [WORD_W-1:0] pack_word(frame_stat_t s);
        logic [WORD_W-1:0] w;
        w               = '0;
        w[FRAME_W-1:0]  = s.num;
        w[ERR_POS]      = s.err;
        w[OK_POS]       = s.ok;
        return w;
    endfunction

endpackage

// File: rtl/sof_pkt_tracker.sv
// Follows one SOF packet from identifier to end of packet.
// It produces three one-cycle requests: clear, commit-good and commit-bad.
// It also produces the interrupt pulse.
// Assumes the strobes are single-cycle and that crc_ok is valid with eop_stb.
module sof_pkt_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic pid_stb,
    input  logic eop_stb,
    input  logic crc_ok,
    output logic clr_stat,
    output logic commit_ok,
    output logic commit_err,
    output logic irq_req
);

    logic pend_q;
    logic eop_live;

    // An end of packet counts only when it closes a pending SOF and no new identifier competes with it.
    assign eop_live   = eop_stb && pend_q && !pid_stb;
    assign clr_stat   = pid_stb;
    assign commit_ok  = eop_live && crc_ok;
    assign commit_err = eop_live && !crc_ok;

    // Pending flag: set by the identifier, dropped at the end of packet.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (pid_stb) pend_q <= 1'b1;
        else if (eop_stb) pend_q <= 1'b0;
    end

    // Interrupt pulse: one cycle after each identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= pid_stb;
    end

    // R2
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pid_stb |=> irq_req);

    // R2
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pid_stb |=> !irq_req);

endmodule

// File: rtl/sof_frame_regs.sv
// Holds the frame number and the two flags.
// Clear and commit requests arrive from the packet tracker and never coincide.
module sof_frame_regs
    import usb_sof_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_stat,
    input  logic               commit_ok,
    input  logic               commit_err,
    input  logic [FRAME_W-1:0] field_in,
    output frame_stat_t        stat
);

    frame_stat_t st_q;

    // Status update: clear at identifier, commit at end of packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (clr_stat) begin
            st_q.ok  <= 1'b0;
            st_q.err <= 1'b0;
        end else if (commit_ok) begin
            st_q.num <= field_in;
            st_q.ok  <= 1'b1;
            st_q.err <= 1'b0;
        end else if (commit_err) begin
            st_q.ok  <= 1'b0;
            st_q.err <= 1'b1;
        end
    end

    assign stat = st_q;

    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ok && st_q.err));

    // R3
    pid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> (!st_q.ok && !st_q.err));

    // R4
    num_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_ok |=> $stable(st_q.num));

    // R6
    bad_keeps_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_err |=> (st_q.err && $stable(st_q.num)));

endmodule

// File: rtl/sof_read_port.sv
// Presents the status word on a single-address read port.
// A parameter selects a registered (one-cycle) read or a combinational read.
module sof_read_port
    import usb_sof_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FRAME_ADDR = 0,
    parameter bit READ_REG   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  frame_stat_t       stat,
    output logic [WORD_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(FRAME_ADDR);

    logic              hit;
    logic [WORD_W-1:0] word_now;

    assign hit      = rd_en && (rd_addr == HIT_ADDR);
    assign word_now = hit ? pack_word(stat) : '0;

    generate
        if (READ_REG) begin : g_reg
            logic [WORD_W-1:0] rd_q;

            // Registered read data, zero when no hit.
            always_ff @(posedge clk) begin
                if (!rst_n) rd_q <= '0;
                else        rd_q <= word_now;
            end

            assign rd_data = rd_q;

            // R10
            miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !hit |=> (rd_q == '0));
        end else begin : g_comb
            assign rd_data = word_now;
        end
    endgenerate

endmodule

// File: rtl/usb_sof_tracker.sv
// Top level of the SOF frame number tracker.
// It connects the packet tracker, the status registers and the read port.
// Expects decoded packet events from the packet layer.
module usb_sof_tracker
    import usb_sof_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FRAME_ADDR = 0,
    parameter bit READ_REG   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_pid_stb,
    input  logic              eop_stb,
    input  logic              crc_ok,
    input  logic [10:0]       frame_field,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              sof_irq
);

    logic        clr_stat;
    logic        commit_ok;
    logic        commit_err;
    frame_stat_t stat;

    sof_pkt_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pid_stb    (sof_pid_stb),
        .eop_stb    (eop_stb),
        .crc_ok     (crc_ok),
        .clr_stat   (clr_stat),
        .commit_ok  (commit_ok),
        .commit_err (commit_err),
        .irq_req    (sof_irq)
    );

    sof_frame_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_stat   (clr_stat),
        .commit_ok  (commit_ok),
        .commit_err (commit_err),
        .field_in   (frame_field),
        .stat       (stat)
    );

    sof_read_port #(
        .ADDR_W     (ADDR_W),
        .FRAME_ADDR (FRAME_ADDR),
        .READ_REG   (READ_REG)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .stat    (stat),
        .rd_data (rd_data)
    );

    // R9
    same_cycle_pid_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_pid_stb && eop_stb) |-> !(commit_ok || commit_err));

endmodule

// File: tb/tb_usb_sof_tracker.sv
module tb_usb_sof_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_pid_stb = 1'b0;
    logic        eop_stb = 1'b0;
    logic        crc_ok = 1'b0;
    logic [10:0] frame_field = '0;
    logic        rd_en = 1'b1;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sof_irq;

    integer n_chk = 0;
    integer n_err = 0;
    integer cyc = 0;
    bit     done = 1'b0;
    string  cur_req = "R1";

    // Behavioural reference state
    integer m_num = 0;
    integer m_ok = 0;
    integer m_err = 0;
    integer m_pend = 0;
    logic [31:0] exp_rd = '0;
    logic        exp_irq = 1'b0;
    bit          model_live = 1'b0;

    always #5 clk = ~clk;

    usb_sof_tracker dut (
        .clk(clk), .rst_n(rst_n), .sof_pid_stb(sof_pid_stb), .eop_stb(eop_stb),
        .crc_ok(crc_ok), .frame_field(frame_field), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .sof_irq(sof_irq)
    );

    function automatic logic [31:0] mk_word(integer num, integer ok, integer er);
        logic [31:0] w;
        w = 32'(num) & 32'h7FF;
        if (er != 0) w = w | 32'h0001_0000;
        if (ok != 0) w = w | 32'h0002_0000;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model: advances on every clock edge from the applied inputs.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            exp_rd = '0; exp_irq = 1'b0;
            m_num = 0; m_ok = 0; m_err = 0; m_pend = 0;
        end else begin
            exp_rd  = (rd_en && rd_addr == 4'd0) ? mk_word(m_num, m_ok, m_err) : 32'h0;
            exp_irq = sof_pid_stb;
            if (sof_pid_stb) begin
                m_ok = 0; m_err = 0; m_pend = 1;
            end else if (eop_stb) begin
                if (m_pend != 0) begin
                    if (crc_ok) begin m_num = int'(frame_field); m_ok = 1; m_err = 0; end
                    else begin m_ok = 0; m_err = 1; end
                end
                m_pend = 0;
            end
        end
    end

    // Compare the outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (model_live && !done) begin
            chk({cur_req, " read word"}, rd_data, exp_rd);
            chk({cur_req, " irq"}, {31'b0, sof_irq}, {31'b0, exp_irq});
            // R7: the flags are never both set
            chk("R7", {31'b0, rd_data[17] & rd_data[16]}, 32'h0);
        end
    end

    task automatic drive(input logic pid, input logic eop, input logic ok, input logic [10:0] f);
        @(negedge clk);
        sof_pid_stb = pid; eop_stb = eop; crc_ok = ok; frame_field = f;
    endtask

    // Idle one cycle, then sample: irq from the previous step, word after that step.
    task automatic settle(output logic irq1, output logic [31:0] w);
        @(negedge clk);
        irq1 = sof_irq;
        sof_pid_stb = 0; eop_stb = 0; crc_ok = 0; frame_field = '0;
        @(negedge clk);
        w = rd_data;
    endtask

    initial begin : stim
        logic        irq1;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'b0, sof_irq}, 32'h0);
        chk("R1 word", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        model_live = 1'b1;
        chk("R1 word after release", rd_data, 32'h0);

        // R2, R4, R5: good SOF
        cur_req = "R4";
        drive(1, 0, 0, 11'h3AA);
        settle(irq1, w);
        chk("R2 irq after pid", {31'b0, irq1}, 32'h1);
        chk("R4 number unchanged at pid", w, 32'h0);
        drive(0, 1, 1, 11'h123);
        settle(irq1, w);
        chk("R2 no irq at eop", {31'b0, irq1}, 32'h0);
        chk("R5 good commit", w, 32'h0002_0123);

        // R3, R6: bad SOF clears ok at pid, keeps number
        cur_req = "R6";
        drive(1, 0, 0, '0);
        settle(irq1, w);
        chk("R3 flags cleared at pid", w, 32'h0000_0123);
        drive(0, 1, 0, 11'h055);
        settle(irq1, w);
        chk("R6 error keeps number", w, 32'h0001_0123);

        // R5: all-ones frame number, clears err at pid
        cur_req = "R5";
        drive(1, 0, 0, '0);
        settle(irq1, w);
        chk("R3 err cleared at pid", w, 32'h0000_0123);
        drive(0, 1, 1, 11'h7FF);
        settle(irq1, w);
        chk("R5 max number", w, 32'h0002_07FF);

        // R8: stray and repeated end of packet ignored
        cur_req = "R8";
        drive(0, 1, 1, 11'h001);
        settle(irq1, w);
        chk("R8 stray eop ignored", w, 32'h0002_07FF);
        drive(0, 1, 0, 11'h002);
        settle(irq1, w);
        chk("R8 stray bad eop ignored", w, 32'h0002_07FF);

        // R9: pid and eop together, pid wins, later eop commits
        cur_req = "R9";
        drive(1, 1, 1, 11'h0F0);
        settle(irq1, w);
        chk("R9 irq", {31'b0, irq1}, 32'h1);
        chk("R9 eop ignored, flags cleared", w, 32'h0000_07FF);
        drive(0, 1, 1, 11'h000);
        settle(irq1, w);
        chk("R9 later eop commits zero", w, 32'h0002_0000);

        // R2: back-to-back identifiers
        cur_req = "R2";
        drive(1, 0, 0, '0);
        drive(1, 0, 0, '0);
        @(negedge clk);
        chk("R2 second irq", {31'b0, sof_irq}, 32'h1);
        sof_pid_stb = 0;
        @(negedge clk);
        chk("R2 irq drops", {31'b0, sof_irq}, 32'h0);
        drive(0, 1, 1, 11'h456);
        settle(irq1, w);
        chk("R5 commit after double pid", w, 32'h0002_0456);

        // R10: other address and no read give zero
        cur_req = "R10";
        @(negedge clk); rd_addr = 4'd5;
        @(negedge clk); @(negedge clk);
        chk("R10 other address", rd_data, 32'h0);
        rd_addr = 4'd0; rd_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 no read", rd_data, 32'h0);
        rd_en = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 read back", rd_data, 32'h0002_0456);

        // R1: reset mid-run returns to zero
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 reset word", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 number zero after reset", rd_data, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk = n_chk + 1;
            n_err = n_err + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule